// File: doc/BRIEF.md
# Packet Length Histogram Classifier

This block takes one length report per packet: a valid strobe, the packet's byte count and a flag that marks the packet as good. For each report it works out which of fourteen length bins the packet falls in. One clock later it raises one increment pulse for that bin, a total-packet pulse, and a good-packet pulse when the packet was good. It also emits the byte count as an increment value for the total-bytes and good-bytes counters.

Its outputs are meant to drive a bank of snapshot counters. That bank adds each pulse or value to its accumulators. The block holds no counts of its own, and it does not parse frames or check frame check sequences.

The bin edges are not all powers of two. Around the untagged and tagged maximum frame sizes there are narrow bins. Runts go to a separate small bin, and packets above the jumbo limit go to a separate large bin.

Top module: `pkt_len_histogram`

## Requirements
- R1: While reset is held and on the first cycle after it, every output is zero.
- R2: Outputs change exactly one clock after a report is sampled: a report sampled on edge n appears on the outputs between edge n and edge n+1.
- R3: For each valid report exactly one bit of `bin_hit` is high; with no valid report `bin_hit` is all zero.
- R4: A length below 64 sets `bin_hit` bit 0 (small bin); a length of exactly 64 sets bit 1.
- R5: Lengths 65..127 set bit 2, 128..255 bit 3, 256..511 bit 4, 512..1023 bit 5.
- R6: Lengths 1024..1518 set bit 6, 1519..1522 bit 7, 1523..1548 bit 8.
- R7: Lengths 1549..2047 set bit 9, 2048..4095 bit 10, 4096..8191 bit 11, 8192..9215 bit 12, and any length above 9215 sets bit 13 (large bin).
- R8: `inc_pkt` is high for one cycle per valid report. `inc_good_pkt` is high only when that report had `rpt_good`=1.
- R9: `inc_bytes` equals the reported length for every valid report. `inc_good_bytes` equals the length for a good report and is zero for a bad one.
- R10: A bad report still raises `inc_pkt`, `inc_bytes` and its length bin.
- R11: Reports on consecutive cycles each produce their own complete output set on consecutive cycles.
- R12: In a cycle after no valid report, all pulses are zero and both byte increments are zero, whatever `rpt_len` and `rpt_good` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rpt_valid | input | 1 | A length report is present this cycle |
| rpt_len | input | LEN_W | Packet length in bytes |
| rpt_good | input | 1 | The packet was received without error |
| inc_pkt | output | 1 | Total-packet increment |
| inc_good_pkt | output | 1 | Good-packet increment |
| inc_bytes | output | LEN_W | Total-bytes increment value |
| inc_good_bytes | output | LEN_W | Good-bytes increment value |
| bin_hit | output | 14 | One-hot length-bin increment, bit index per R4..R7 |

## Verification
In any one cycle the block can be classifying a new report while the result of the previous report sits on the outputs. Back-to-back reports make this happen. The bench streams pairs of reports on consecutive cycles, placing the lengths on opposite sides of a bin edge and alternating the good flag. It then checks each output cycle against the expected result for its own report only. A mixed-up pair would show up as a wrong bin bit, a wrong byte value, or a good pulse on the wrong cycle.

// File: rtl/pkt_hist_pkg.sv
// Shared constants and the bin-floor computation for the length histogram.
// Assumes the bin edges are strictly increasing for the chosen parameters.
package pkt_hist_pkg;

    localparam int NBINS = 14;

    // Lowest length that lands in bin k (k = 1..NBINS-1); bin 0 starts at 0.
    function automatic int bin_floor(input int k, input int mn, input int sm,
                                     input int tm, input int em, input int jm);
        case (k)
            1:       return mn;
            2:       return mn + 1;
            3:       return mn * 2;
            4:       return mn * 4;
            5:       return mn * 8;
            6:       return mn * 16;
            7:       return sm + 1;
            8:       return tm + 1;
            9:       return em + 1;
            10:      return mn * 32;
            11:      return mn * 64;
            12:      return mn * 128;
            default: return jm + 1;
        endcase
    endfunction

endpackage

// File: rtl/pkt_len_edge_cmp.sv
// One bin edge: reports whether the length reaches the edge's floor.
// Assumes FLOOR fits in LEN_W bits.
module pkt_len_edge_cmp #(
    parameter int LEN_W = 14,
    parameter int FLOOR = 64
) (
    input  logic [LEN_W-1:0] len,
    output logic             at_or_above
);
    localparam logic [LEN_W-1:0] FLOOR_V = FLOOR[LEN_W-1:0];

    // Plain magnitude compare against the constant floor.
    always_comb at_or_above = (len >= FLOOR_V);
endmodule

// File: rtl/pkt_len_binner.sv
// Combinational classifier: builds a thermometer code from one comparator per
// edge and turns it into a one-hot bin vector, gated by the valid strobe.
// Assumes the floors increase with bin index.
module pkt_len_binner
    import pkt_hist_pkg::*;
#(
    parameter int LEN_W     = 14,
    parameter int MIN_LEN   = 64,
    parameter int STD_MAX   = 1518,
    parameter int TAG_MAX   = 1522,
    parameter int ENV_MAX   = 1548,
    parameter int JUMBO_MAX = 9215
) (
    input  logic             valid,
    input  logic [LEN_W-1:0] len,
    output logic [NBINS-1:0] hot
);
    logic [NBINS:0] thermo;

    assign thermo[0]     = 1'b1;
    assign thermo[NBINS] = 1'b0;

    // One comparator per edge between adjacent bins.
    for (genvar k = 1; k < NBINS; k++) begin : g_edge
        pkt_len_edge_cmp #(
            .LEN_W (LEN_W),
            .FLOOR (bin_floor(k, MIN_LEN, STD_MAX, TAG_MAX, ENV_MAX, JUMBO_MAX))
        ) u_cmp (
            .len         (len),
            .at_or_above (thermo[k])
        );
    end

    // Edge-detect the thermometer: the highest reached floor marks the bin.
    for (genvar i = 0; i < NBINS; i++) begin : g_hot
        assign hot[i] = valid & thermo[i] & ~thermo[i+1];
    end
endmodule

// File: rtl/pkt_len_stats_reg.sv
// Output stage: registers the packet, good and byte increments and the bin
// vector so every output is a flop. Assumes a synchronous active-low reset.
module pkt_len_stats_reg
    import pkt_hist_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             good,
    input  logic [LEN_W-1:0] len,
    input  logic [NBINS-1:0] hot,
    output logic             inc_pkt,
    output logic             inc_good_pkt,
    output logic [LEN_W-1:0] inc_bytes,
    output logic [LEN_W-1:0] inc_good_bytes,
    output logic [NBINS-1:0] bin_hit
);
    // Capture one cycle of increments; idle cycles produce all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_pkt        <= 1'b0;
            inc_good_pkt   <= 1'b0;
            inc_bytes      <= '0;
            inc_good_bytes <= '0;
            bin_hit        <= '0;
        end else begin
            inc_pkt        <= valid;
            inc_good_pkt   <= valid & good;
            inc_bytes      <= valid ? len : '0;
            inc_good_bytes <= (valid & good) ? len : '0;
            bin_hit        <= hot;
        end
    end
endmodule

// File: rtl/pkt_len_histogram.sv
// Top: classifies each packet-length report into one histogram bin and emits
// one-cycle increments for a downstream snapshot counter bank.
// Assumes at most one report per cycle.
module pkt_len_histogram
    import pkt_hist_pkg::*;
#(
    parameter int LEN_W     = 14,
    parameter int MIN_LEN   = 64,
    parameter int STD_MAX   = 1518,
    parameter int TAG_MAX   = 1522,
    parameter int ENV_MAX   = 1548,
    parameter int JUMBO_MAX = 9215
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rpt_valid,
    input  logic [LEN_W-1:0] rpt_len,
    input  logic             rpt_good,
    output logic             inc_pkt,
    output logic             inc_good_pkt,
    output logic [LEN_W-1:0] inc_bytes,
    output logic [LEN_W-1:0] inc_good_bytes,
    output logic [NBINS-1:0] bin_hit
);
    logic [NBINS-1:0] hot;

    // Combinational bin selection.
    pkt_len_binner #(
        .LEN_W (LEN_W), .MIN_LEN (MIN_LEN), .STD_MAX (STD_MAX),
        .TAG_MAX (TAG_MAX), .ENV_MAX (ENV_MAX), .JUMBO_MAX (JUMBO_MAX)
    ) u_binner (
        .valid (rpt_valid),
        .len   (rpt_len),
        .hot   (hot)
    );

    // Registered increment outputs.
    pkt_len_stats_reg #(.LEN_W (LEN_W)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .valid          (rpt_valid),
        .good           (rpt_good),
        .len            (rpt_len),
        .hot            (hot),
        .inc_pkt        (inc_pkt),
        .inc_good_pkt   (inc_good_pkt),
        .inc_bytes      (inc_bytes),
        .inc_good_bytes (inc_good_bytes),
        .bin_hit        (bin_hit)
    );
endmodule

// File: rtl/pkt_len_histogram_chk.sv
// Checker for the histogram classifier: relates the ports across one cycle.
// Assumes it is bound to every instance of pkt_len_histogram.
module pkt_len_histogram_chk
    import pkt_hist_pkg::*;
#(
    parameter int LEN_W     = 14,
    parameter int MIN_LEN   = 64,
    parameter int JUMBO_MAX = 9215
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rpt_valid,
    input logic [LEN_W-1:0] rpt_len,
    input logic             rpt_good,
    input logic             inc_pkt,
    input logic             inc_good_pkt,
    input logic [LEN_W-1:0] inc_bytes,
    input logic [LEN_W-1:0] inc_good_bytes,
    input logic [NBINS-1:0] bin_hit
);
    localparam logic [LEN_W-1:0] MIN_V   = MIN_LEN[LEN_W-1:0];
    localparam logic [LEN_W-1:0] JUMBO_V = JUMBO_MAX[LEN_W-1:0];

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |=> inc_pkt);
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_valid |=> (!inc_pkt && bin_hit == '0 && inc_bytes == '0));
    p_one_bin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inc_pkt |-> ($countones(bin_hit) == 1));
    p_no_stray_bin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_pkt |-> (bin_hit == '0));
    p_small_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_len < MIN_V) |=> bin_hit[0]);
    p_large_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_len > JUMBO_V) |=> bin_hit[NBINS-1]);
    p_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |=> (inc_good_pkt == $past(rpt_good)));
    p_bytes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |=> (inc_bytes == $past(rpt_len)));
    p_good_bytes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_good_pkt |-> (inc_good_bytes == '0));
endmodule

bind pkt_len_histogram pkt_len_histogram_chk #(
    .LEN_W (LEN_W), .MIN_LEN (MIN_LEN), .JUMBO_MAX (JUMBO_MAX)
) u_chk (
    .clk (clk), .rst_n (rst_n), .rpt_valid (rpt_valid), .rpt_len (rpt_len),
    .rpt_good (rpt_good), .inc_pkt (inc_pkt), .inc_good_pkt (inc_good_pkt),
    .inc_bytes (inc_bytes), .inc_good_bytes (inc_good_bytes),
    .bin_hit (bin_hit)
);

// File: tb/sim_pkt_len_histogram.sv
// Directed bench for the packet length histogram classifier.
module sim_pkt_len_histogram;
    localparam int LEN_W = 14;
    localparam int NB    = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rpt_valid = 1'b0;
    logic [LEN_W-1:0] rpt_len = '0;
    logic             rpt_good = 1'b0;
    logic             inc_pkt, inc_good_pkt;
    logic [LEN_W-1:0] inc_bytes, inc_good_bytes;
    logic [NB-1:0]    bin_hit;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    pkt_len_histogram u0 (
        .clk (clk), .rst_n (rst_n), .rpt_valid (rpt_valid), .rpt_len (rpt_len),
        .rpt_good (rpt_good), .inc_pkt (inc_pkt), .inc_good_pkt (inc_good_pkt),
        .inc_bytes (inc_bytes), .inc_good_bytes (inc_good_bytes),
        .bin_hit (bin_hit)
    );

    // Expected bin index written directly from R4..R7.
    function automatic int exp_bin(input int len);
        if (len < 64)        return 0;
        if (len == 64)       return 1;
        if (len <= 127)      return 2;
        if (len <= 255)      return 3;
        if (len <= 511)      return 4;
        if (len <= 1023)     return 5;
        if (len <= 1518)     return 6;
        if (len <= 1522)     return 7;
        if (len <= 1548)     return 8;
        if (len <= 2047)     return 9;
        if (len <= 4095)     return 10;
        if (len <= 8191)     return 11;
        if (len <= 9215)     return 12;
        return 13;
    endfunction

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs against one report (or idle when v=0).
    task automatic chk_out(input string req, input bit v, input int len, input bit g);
        chk(req, "inc_pkt", inc_pkt, v);
        chk(req, "inc_good_pkt", inc_good_pkt, v & g);
        chk(req, "inc_bytes", inc_bytes, v ? len : 0);
        chk(req, "inc_good_bytes", inc_good_bytes, (v & g) ? len : 0);
        chk(req, "bin_hit", bin_hit, v ? (longint'(1) << exp_bin(len)) : 0);
    endtask

    // One report, outputs checked one cycle later.
    task automatic send(input string req, input int len, input bit g);
        rpt_valid = 1'b1; rpt_len = LEN_W'(len); rpt_good = g;
        @(negedge clk);
        rpt_valid = 1'b0;
        chk_out(req, 1'b1, len, g);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; rpt_valid = 1'b1; rpt_len = 14'd100; rpt_good = 1'b1;
        repeat (3) @(negedge clk);
        chk_out("R1", 1'b0, 0, 1'b0);
        rpt_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1", 1'b0, 0, 1'b0);
    endtask

    task automatic t_edges;
        int lens[28] = '{0, 1, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023,
                         1024, 1518, 1519, 1522, 1523, 1548, 1549, 2047, 2048,
                         4095, 4096, 8191, 8192, 9215, 9216, 16383};
        for (int i = 0; i < 28; i++) begin
            if (lens[i] <= 64)        send("R4", lens[i], 1'b1);
            else if (lens[i] <= 1023) send("R5", lens[i], 1'b1);
            else if (lens[i] <= 1548) send("R6", lens[i], 1'b1);
            else                      send("R7", lens[i], 1'b1);
            @(negedge clk);
            chk_out("R3", 1'b0, 0, 1'b0);
        end
    endtask

    task automatic t_good_bad;
        send("R8", 300, 1'b1);
        send("R10", 300, 1'b0);
        send("R9", 1520, 1'b0);
        send("R9", 9000, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_back_to_back;
        rpt_valid = 1'b1; rpt_len = 14'd1518; rpt_good = 1'b1;
        @(negedge clk);
        chk_out("R11", 1'b1, 1518, 1'b1);
        rpt_len = 14'd1519; rpt_good = 1'b0;
        @(negedge clk);
        chk_out("R11", 1'b1, 1519, 1'b0);
        rpt_len = 14'd63; rpt_good = 1'b1;
        @(negedge clk);
        chk_out("R11", 1'b1, 63, 1'b1);
        rpt_valid = 1'b0;
        @(negedge clk);
        chk_out("R2", 1'b0, 0, 1'b0);
    endtask

    task automatic t_idle;
        rpt_valid = 1'b0; rpt_len = 14'd9999; rpt_good = 1'b1;
        repeat (2) @(negedge clk);
        chk_out("R12", 1'b0, 0, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_edges();
        t_good_bad();
        t_back_to_back();
        t_idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule